// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one block-transfer command into a stream of single-word transfers. A command carries a base address, a register-select mask, one of four addressing modes and a writeback flag. The block issues one transfer per accepted handshake. Each transfer carries a word address and the number of a selected register. When the last transfer has gone out, it reports the base value the caller should write back.

The register with the lowest index always takes the lowest address. Registers are therefore issued in ascending index order, and addresses climb one word at a time, in every mode. The decrement modes first move the start address below the base by the size of the whole block. A stack push is decrement-before with writeback on the stack pointer. A stack pop is increment-after with writeback. The block does not access memory or the register file. It only produces the sequence of addresses and register numbers.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `xfer_valid` and `done` are 0.
- R2: Each register whose mask bit is set is issued exactly once, in strictly ascending index order. No other register is issued.
- R3: Each transfer after the first of a command has an address one word (WORD_BYTES, default 4) above the address of the previous transfer.
- R4: Let n be the number of set mask bits. The first address is determined by `cmd_mode`. Mode 0 (increment after) gives base. Mode 1 (increment before) gives base+4. Mode 2 (decrement after) gives base−4n+4. Mode 3 (decrement before) gives base−4n. All arithmetic is modulo 2^ADDR_W.
- R5: With `cmd_wb`=1, `done_base` is base+4n in modes 0 and 1 and base−4n in modes 2 and 3.
- R6: With `cmd_wb`=0, `done_base` equals the command's base.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. With a non-empty mask, the first transfer is valid in the following cycle. With an empty mask, no transfer is issued, `done` rises in the following cycle, and `done_base` equals the base.
- R8: While `xfer_valid` is high and `xfer_ready` is low, the transfer is held: `xfer_valid`, `xfer_addr` and `xfer_reg` keep their values in the next cycle.
- R9: `done` is high for exactly one cycle per command. `cmd_ready` is low while a command is in progress, and command inputs offered during that time have no effect on the transfer stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | ADDR_W | Base address |
| cmd_list | input | LIST_W | Register-select mask, bit i selects register i |
| cmd_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| cmd_wb | input | 1 | Report the updated base instead of the original |
| xfer_valid | output | 1 | Transfer presented |
| xfer_ready | input | 1 | Transfer taken by the consumer |
| xfer_addr | output | ADDR_W | Word address of the transfer |
| xfer_reg | output | IDX_W | Register number of the transfer |
| done | output | 1 | One-cycle end-of-command pulse |
| done_base | output | ADDR_W | Base value to write back, valid with done |

## Verification
Several behaviours are checked by properties on every cycle. These are holding a stalled transfer, the one-word address step, the strictly rising register index, the count of transfers equal to the mask population, the single-cycle done pulse, the exclusion of `cmd_ready` from busy cycles, and done following an empty command. Other behaviours depend on the arithmetic tying a command to its results: the mode-dependent start address, the written-back base with and without writeback, and the exact latency after acceptance. Only the bench's sweeps show these, by comparing every transfer against values computed from the command. The sweeps cover all modes, both writeback settings, single-bit, full, empty and scattered masks, backpressure patterns and commands offered while busy.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

   typedef enum logic [1:0] {
      XM_INC_AFTER  = 2'b00,
      XM_INC_BEFORE = 2'b01,
      XM_DEC_AFTER  = 2'b10,
      XM_DEC_BEFORE = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      XS_IDLE = 2'b00,
      XS_RUN  = 2'b01,
      XS_FIN  = 2'b10
   } xfer_state_e;

endpackage

// File: rtl/xfer_popcount.sv
module xfer_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits,
   output logic [CW-1:0] count
);
   logic [CW-1:0] part [W+1];

   assign part[0] = '0;
   for (genvar i = 0; i < W; i++) begin : g_acc
      assign part[i+1] = part[i] + CW'(bits[i]);
   end

   assign count = part[W];
endmodule

// File: rtl/xfer_lowest.sv
module xfer_lowest #(
   parameter int W    = 16,
   parameter int IMPL = 0,
   parameter int IW   = $clog2(W)
) (
   input  logic [W-1:0]  bits,
   output logic [IW-1:0] idx
);
   if (IMPL == 0) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
         end
      end
   end else begin : g_onehot
      logic [W-1:0] oh;
      assign oh = bits & (~bits + W'(1));
      for (genvar j = 0; j < IW; j++) begin : g_bit
         logic [W-1:0] sel;
         for (genvar i = 0; i < W; i++) begin : g_sel
            if (((i >> j) & 1) == 1) begin : g_on
               assign sel[i] = oh[i];
            end else begin : g_off
               assign sel[i] = 1'b0;
            end
         end
         assign idx[j] = |sel;
      end
   end
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc
   import xfer_seq_pkg::*;
#(
   parameter int AW   = 32,
   parameter int CW   = 5,
   parameter int STEP = 4
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] cnt,
   input  logic [1:0]    mode,
   input  logic          wb,
   output logic [AW-1:0] start,
   output logic [AW-1:0] final_base
);
   localparam int SH = $clog2(STEP);

   logic [AW-1:0] span;
   logic [AW-1:0] end_base;

   assign span = AW'(cnt) << SH;

   always_comb begin
      case (xfer_mode_e'(mode))
         XM_INC_AFTER: begin
            start    = base;
            end_base = base + span;
         end
         XM_INC_BEFORE: begin
            start    = base + AW'(STEP);
            end_base = base + span;
         end
         XM_DEC_AFTER: begin
            start    = base - span + AW'(STEP);
            end_base = base - span;
         end
         default: begin
            start    = base - span;
            end_base = base - span;
         end
      endcase
   end

   assign final_base = wb ? end_base : base;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
   import xfer_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int PRIO_IMPL  = 0,
   localparam int IDX_W     = $clog2(LIST_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [LIST_W-1:0] cmd_list,
   input  logic [1:0]        cmd_mode,
   input  logic              cmd_wb,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [IDX_W-1:0]  xfer_reg,
   output logic              done,
   output logic [ADDR_W-1:0] done_base
);
   localparam int CNT_W = $clog2(LIST_W + 1);

   if (LIST_W < 2 || ADDR_W < 8) begin : g_bad_width
      $error("blk_xfer_seq: LIST_W must be >= 2 and ADDR_W >= 8");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_step
      $error("blk_xfer_seq: WORD_BYTES must be a power of two");
   end
   if (PRIO_IMPL < 0 || PRIO_IMPL > 1) begin : g_bad_impl
      $error("blk_xfer_seq: PRIO_IMPL must be 0 or 1");
   end

   xfer_state_e       state_q;
   logic [LIST_W-1:0] list_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] fbase_q;

   logic [CNT_W-1:0]  cmd_cnt;
   logic [ADDR_W-1:0] cmd_start;
   logic [ADDR_W-1:0] cmd_final;
   logic [IDX_W-1:0]  cur_idx;
   logic [LIST_W-1:0] list_clr;

   xfer_popcount #(.W(LIST_W), .CW(CNT_W)) i_cnt (
      .bits  (cmd_list),
      .count (cmd_cnt)
   );

   xfer_addr_calc #(.AW(ADDR_W), .CW(CNT_W), .STEP(WORD_BYTES)) i_calc (
      .base       (cmd_base),
      .cnt        (cmd_cnt),
      .mode       (cmd_mode),
      .wb         (cmd_wb),
      .start      (cmd_start),
      .final_base (cmd_final)
   );

   xfer_lowest #(.W(LIST_W), .IMPL(PRIO_IMPL), .IW(IDX_W)) i_low (
      .bits (list_q),
      .idx  (cur_idx)
   );

   assign list_clr = list_q & ~(LIST_W'(1) << cur_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         list_q  <= '0;
         addr_q  <= '0;
         fbase_q <= '0;
      end else begin
         case (state_q)
            XS_IDLE: begin
               if (cmd_valid) begin
                  list_q  <= cmd_list;
                  addr_q  <= cmd_start;
                  fbase_q <= cmd_final;
                  state_q <= (|cmd_list) ? XS_RUN : XS_FIN;
               end
            end
            XS_RUN: begin
               if (xfer_ready) begin
                  list_q <= list_clr;
                  addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                  if (list_clr == '0) state_q <= XS_FIN;
               end
            end
            XS_FIN:  state_q <= XS_IDLE;
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign cmd_ready  = (state_q == XS_IDLE);
   assign xfer_valid = (state_q == XS_RUN);
   assign xfer_addr  = addr_q;
   assign xfer_reg   = cur_idx;
   assign done       = (state_q == XS_FIN);
   assign done_base  = fbase_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [LIST_W-1:0] cmd_list,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [IDX_W-1:0]  xfer_reg,
   input logic              done
);
   int exp_cnt;
   int seen_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_cnt  <= 0;
         seen_cnt <= 0;
      end else if (cmd_valid && cmd_ready) begin
         exp_cnt  <= $countones(cmd_list);
         seen_cnt <= 0;
      end else if (xfer_valid && xfer_ready) begin
         seen_cnt <= seen_cnt + 1;
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=>
         (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg)));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready) |=>
         (!xfer_valid || xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES)));

   p_reg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_reg > $past(xfer_reg)));

   p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (seen_cnt == exp_cnt));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_ready && (xfer_valid || done)));

   p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_list == '0) |=> (done && !xfer_valid));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
   .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_list   (cmd_list),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_addr  (xfer_addr),
   .xfer_reg   (xfer_reg),
   .done       (done)
);

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_base = '0;
   logic [15:0] cmd_list = '0;
   logic [1:0]  cmd_mode = '0;
   logic        cmd_wb = 1'b0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [31:0] xfer_addr;
   logic [3:0]  xfer_reg;
   logic        done;
   logic [31:0] done_base;

   int vectors = 0;
   int miscmp  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   blk_xfer_seq i_blk_xfer_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_base(cmd_base), .cmd_list(cmd_list), .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
      .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
      .done(done), .done_base(done_base)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscmp++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [31:0] base, input logic [15:0] lst,
                          input logic [1:0] mode, input logic wb,
                          input int stall, input bit junk);
      int n, k, cyc, e;
      logic [31:0] start, fin, exp_a, held_a;
      logic [15:0] rem;
      logic [3:0]  held_r;
      bit          prev_stall;
      n = $countones(lst);
      case (mode)
         2'd0: start = base;
         2'd1: start = base + 32'd4;
         2'd2: start = base - 32'(4 * n) + 32'd4;
         default: start = base - 32'(4 * n);
      endcase
      if (!wb) fin = base;
      else if (mode[1]) fin = base - 32'(4 * n);
      else fin = base + 32'(4 * n);

      @(negedge clk);
      chk(cmd_ready == 1'b1, "R9 ready when idle", 32'(cmd_ready), 32'd1);
      cmd_base = base; cmd_list = lst; cmd_mode = mode; cmd_wb = wb; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = junk;
      if (junk) begin
         cmd_base = ~base; cmd_list = ~lst; cmd_mode = ~mode; cmd_wb = ~wb;
      end
      rem = lst; k = 0; cyc = 1; prev_stall = 0; held_a = '0; held_r = '0;
      while (1) begin
         xfer_ready = (stall == 0) ? 1'b1 : (((cyc * 7 + stall) % 3) != 0);
         if (cyc == 1) begin
            if (n == 0) chk(done && !xfer_valid, "R7 empty list done next cycle", 32'(done), 32'd1);
            else        chk(xfer_valid, "R7 first transfer next cycle", 32'(xfer_valid), 32'd1);
         end
         if (xfer_valid || done)
            chk(!cmd_ready, "R9 not ready while busy", 32'(cmd_ready), 32'd0);
         if (prev_stall) begin
            chk(xfer_valid, "R8 stalled valid held", 32'(xfer_valid), 32'd1);
            chk(xfer_addr == held_a && xfer_reg == held_r, "R8 stalled transfer stable",
                {xfer_addr[27:0], xfer_reg}, {held_a[27:0], held_r});
         end
         if (done) begin
            chk(k == n, "R2 transfer count", 32'(k), 32'(n));
            if (wb) chk(done_base == fin, "R5 writeback base", done_base, fin);
            else    chk(done_base == fin, "R6 base unchanged", done_base, fin);
            cmd_valid = 1'b0;
            xfer_ready = 1'b0;
            @(negedge clk);
            chk(!done, "R9 done single cycle", 32'(done), 32'd0);
            break;
         end
         prev_stall = xfer_valid && !xfer_ready;
         held_a = xfer_addr; held_r = xfer_reg;
         if (xfer_valid && xfer_ready) begin
            e = 0;
            for (int i = 15; i >= 0; i--) if (rem[i]) e = i;
            exp_a = start + 32'(4 * k);
            chk(k < n && xfer_reg == 4'(e), "R2 register order", 32'(xfer_reg), 32'(e));
            if (k == 0) chk(xfer_addr == exp_a, "R4 start address", xfer_addr, exp_a);
            else        chk(xfer_addr == exp_a, "R3 address step", xfer_addr, exp_a);
            rem[e] = 1'b0;
            k++;
         end
         cyc++;
         if (cyc > 400) begin
            chk(0, "watchdog command hung", 32'(cyc), 32'd0);
            cmd_valid = 1'b0;
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      #(8ns * 190000);
      if (!finished) begin
         chk(0, "watchdog global timeout", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

   initial begin
      logic [15:0] l;
      logic [31:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !xfer_valid && !done, "R1 reset state",
          {29'd0, cmd_ready, xfer_valid, done}, 32'd4);

      // stack push of R0,R1,R7 from 0x8000, then pop back
      run_cmd(32'h0000_8000, 16'h0083, 2'd3, 1'b1, 0, 1'b0);
      run_cmd(32'h0000_7FF4, 16'h0083, 2'd0, 1'b1, 0, 1'b0);

      for (int m = 0; m < 4; m++) begin
         for (int w = 0; w < 2; w++) begin
            for (int li = 0; li < 40; li++) begin
               if (li < 16)       l = 16'(1 << li);
               else if (li == 16) l = 16'h0000;
               else if (li == 17) l = 16'hFFFF;
               else if (li == 18) l = 16'h8001;
               else               l = 16'(li * 16'h9E37) ^ 16'(li << 7);
               b = 32'h0000_8000 ^ 32'(li * 32'h0001_0010);
               if (li == 19) b = 32'h0000_0000;
               run_cmd(b, l, 2'(m), 1'(w), (li % 2) * (li + m), (li % 5) == 0);
            end
         end
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end
endmodule